// File: doc/BRIEF.md
# Multi-level priority interrupt controller

This block arbitrates twenty-seven prioritised interrupt levels for a small processor. Each level has a request line. The block samples those lines only when the processor reports the end of an instruction. It keeps a register that records which levels are currently being serviced. A sampled request is accepted only when it outranks every level in that register. On acceptance the block emits a one-cycle take pulse. With it come the accepted level and a fixed vector address, and the processor uses that address for a forced branch-and-store-return. The accepted level is also marked in service.

The levels are ordered from highest to lowest priority:

- the internal-error level;
- twenty-four external levels, numbered 0 to 23;
- the trace level;
- the CE level.

When the processor executes a branch-out-of-interrupt, it signals the block. The block then drops the highest-priority level in service, which lets lower requests that were held off through. Two groups of six external levels are optional, and each group has its own enable parameter. External levels are never taken at the end of an I/O-execute instruction or a branch-and-store instruction.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `active` is all zero and `take_irq` is low.
- R2: Requests are sampled only in a cycle with `insn_end` high. Without it, `take_irq` stays low on the next cycle and `active` does not gain a bit.
- R3: The level index used for `grant_level` and `active` is as follows: 0 for internal error, n+1 for external level n, 25 for trace and 26 for CE. A lower index has higher priority, and among sampled requests the lowest index wins.
- R4: A sampled request is accepted only if its index is strictly lower than that of every level still in service. A request is held off while a level of equal or higher priority is in service.
- R5: On acceptance, `take_irq` is high for the one cycle after the sampling edge. `grant_level` carries the accepted index, and that index's bit is set in `active`.
- R6: `vector` gives a word address for the accepted level:
  - internal error uses VEC_BASE (8);
  - trace uses VEC_BASE+1 (9);
  - CE uses VEC_BASE+2 (10);
  - external level n uses VEC_BASE+3+n, which runs from 11 to 34.
- R7: A return occurs when `branch_done` and `branch_bo` are high in the same cycle. It clears only the lowest-index set bit of `active`.
- R8: `branch_done` with `branch_bo` low (an ordinary conditional branch) leaves `active` unchanged.
- R9: A return while `active` is zero has no effect.
- R10: When `end_was_xio` or `end_was_bsi` is high in the sampling cycle, external requests are ignored. Internal, trace and CE requests can still be taken.
- R11: With GRP1_EN=0, requests on external levels 12 to 17 are never taken. With GRP2_EN=0, the same holds for external levels 18 to 23.
- R12: When a return and a sampling edge fall in the same cycle, the return is applied first. The request is then compared against the levels that remain in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 1 | Internal-error level request |
| ext_req | input | 24 | External level requests, bit n = external level n |
| trace_req | input | 1 | Trace level request |
| ce_req | input | 1 | CE level request |
| insn_end | input | 1 | Instruction boundary strobe; requests are sampled here |
| end_was_xio | input | 1 | Finished instruction was an I/O execute |
| end_was_bsi | input | 1 | Finished instruction was a branch-and-store |
| branch_done | input | 1 | A conditional branch completed |
| branch_bo | input | 1 | Bit 9 of that branch; set marks a return from interrupt |
| take_irq | output | 1 | One-cycle forced-branch request |
| vector | output | 16 | Word address for the forced branch |
| grant_level | output | 5 | Index of the accepted level |
| active | output | 27 | Levels in service, bit per level index |

## Verification
The return and the sampling of requests can fall in the same cycle. The order in which they are resolved decides whether a request equal to or below the level being released is accepted. The bench provokes this case directly. It takes a level, then in one cycle both raises a return and requests that same level, and expects the level to be re-accepted. It then builds a two-deep nesting and repeats the coincidence with a request below the remaining level, and expects it to be held off. The random phase makes returns and boundaries collide often. Each outcome is judged against a bench model that applies the return before the comparison.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int EXT_LEVELS = 24;
  localparam int GRP_SIZE   = 6;
  localparam int GRP1_FIRST = 12;
  localparam int GRP2_FIRST = GRP1_FIRST + GRP_SIZE;
  localparam int LEVELS     = EXT_LEVELS + 3;
  localparam int IDX_W      = $clog2(LEVELS);
  localparam int IDX_INT    = 0;
  localparam int IDX_EXT0   = 1;
  localparam int IDX_TRACE  = EXT_LEVELS + 1;
  localparam int IDX_CE     = EXT_LEVELS + 2;

  // Fixed word address of each level's forced branch.
  function automatic int vector_of(input int idx, input int base);
    if (idx == IDX_INT)        return base;
    else if (idx == IDX_TRACE) return base + 1;
    else if (idx == IDX_CE)    return base + 2;
    else                       return base + 3 + (idx - IDX_EXT0);
  endfunction
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 27,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  // Lowest set index wins: scan downward so the last hit is the lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
  import prio_irq_pkg::*;
#(
  parameter bit GRP1_EN = 1'b1,
  parameter bit GRP2_EN = 1'b1
) (
  input  logic                  int_req,
  input  logic [EXT_LEVELS-1:0] ext_req,
  input  logic                  trace_req,
  input  logic                  ce_req,
  input  logic                  sample,
  input  logic                  block_ext,
  output logic [LEVELS-1:0]     cand
);
  assign cand[IDX_INT]   = sample & int_req;
  assign cand[IDX_TRACE] = sample & trace_req;
  assign cand[IDX_CE]    = sample & ce_req;

  for (genvar g = 0; g < EXT_LEVELS; g++) begin : g_ext
    localparam logic LVL_ON = (g >= GRP2_FIRST) ? GRP2_EN :
                              (g >= GRP1_FIRST) ? GRP1_EN : 1'b1;
    assign cand[IDX_EXT0+g] = sample & ~block_ext & ext_req[g] & LVL_ON;
  end
endmodule

// File: rtl/irq_active_set.sv
module irq_active_set
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ret,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  output logic [LEVELS-1:0] active_q,
  output logic              rem_found,
  output logic [IDX_W-1:0]  rem_idx
);
  logic              top_found;
  logic [IDX_W-1:0]  top_idx;
  logic [LEVELS-1:0] remaining;
  logic [LEVELS-1:0] active_d;

  irq_first_set #(.N(LEVELS), .W(IDX_W)) u_top (
    .vec(active_q), .found(top_found), .idx(top_idx)
  );

  // A return drops the highest-priority level in service before any grant.
  always_comb begin
    remaining = active_q;
    if (ret && top_found) remaining[top_idx] = 1'b0;
  end

  irq_first_set #(.N(LEVELS), .W(IDX_W)) u_rem (
    .vec(remaining), .found(rem_found), .idx(rem_idx)
  );

  always_comb begin
    active_d = remaining;
    if (set_en) active_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active_d;
  end

  // R7
  ret_drops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && top_found && !set_en) |=>
      ($countones(active_q) == $past($countones(active_q)) - 1));

  // R7
  ret_drops_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && top_found && !set_en) |=> !active_q[$past(top_idx)]);

  // R9
  idle_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && active_q == '0 && !set_en) |=> (active_q == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 8,
  parameter bit GRP1_EN  = 1'b1,
  parameter bit GRP2_EN  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  int_req,
  input  logic [EXT_LEVELS-1:0] ext_req,
  input  logic                  trace_req,
  input  logic                  ce_req,
  input  logic                  insn_end,
  input  logic                  end_was_xio,
  input  logic                  end_was_bsi,
  input  logic                  branch_done,
  input  logic                  branch_bo,
  output logic                  take_irq,
  output logic [VEC_W-1:0]      vector,
  output logic [IDX_W-1:0]      grant_level,
  output logic [LEVELS-1:0]     active
);
  logic              block_ext;
  logic              ret;
  logic [LEVELS-1:0] cand;
  logic              pend_found;
  logic [IDX_W-1:0]  pend_idx;
  logic              rem_found;
  logic [IDX_W-1:0]  rem_idx;
  logic              accept;

  assign block_ext = end_was_xio | end_was_bsi;
  assign ret       = branch_done & branch_bo;

  irq_req_gate #(.GRP1_EN(GRP1_EN), .GRP2_EN(GRP2_EN)) u_gate (
    .int_req(int_req), .ext_req(ext_req), .trace_req(trace_req),
    .ce_req(ce_req), .sample(insn_end), .block_ext(block_ext), .cand(cand)
  );

  irq_first_set #(.N(LEVELS), .W(IDX_W)) u_pend (
    .vec(cand), .found(pend_found), .idx(pend_idx)
  );

  irq_active_set u_active (
    .clk(clk), .rst(rst), .ret(ret), .set_en(accept), .set_idx(pend_idx),
    .active_q(active), .rem_found(rem_found), .rem_idx(rem_idx)
  );

  assign accept = pend_found && (!rem_found || (pend_idx < rem_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq    <= 1'b0;
      vector      <= '0;
      grant_level <= '0;
    end else begin
      take_irq <= accept;
      if (accept) begin
        grant_level <= pend_idx;
        vector      <= VEC_W'(vector_of(int'(pend_idx), VEC_BASE));
      end
    end
  end

  // Levels at or above the granted one, for the ranking check below.
  logic [LEVELS-1:0] at_or_above;
  always_comb begin
    for (int i = 0; i < LEVELS; i++) at_or_above[i] = (i <= int'(grant_level));
  end

  // R5
  grant_marked_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> active[grant_level]);

  // R4
  outranks_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> ($countones(active & at_or_above) == 1));

  // R2
  boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(insn_end) |-> !take_irq);

  // R10
  ext_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (take_irq && $past(insn_end && block_ext)) |->
      !((int'(grant_level) >= IDX_EXT0) && (int'(grant_level) < IDX_TRACE)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_req, trace_req, ce_req;
  logic [23:0] ext_req;
  logic        insn_end, end_was_xio, end_was_bsi, branch_done, branch_bo;
  logic        take_irq, take2;
  logic [15:0] vector, vector2;
  logic [4:0]  grant_level, grant2;
  logic [26:0] active, active2;

  int checks = 0;
  int errors = 0;
  logic [26:0] m_act = '0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .int_req(int_req), .ext_req(ext_req),
    .trace_req(trace_req), .ce_req(ce_req), .insn_end(insn_end),
    .end_was_xio(end_was_xio), .end_was_bsi(end_was_bsi),
    .branch_done(branch_done), .branch_bo(branch_bo),
    .take_irq(take_irq), .vector(vector), .grant_level(grant_level),
    .active(active)
  );

  prio_irq_ctrl #(.GRP2_EN(1'b0)) u_prio_irq_ctrl_g2off (
    .clk(clk), .rst(rst), .int_req(int_req), .ext_req(ext_req),
    .trace_req(trace_req), .ce_req(ce_req), .insn_end(insn_end),
    .end_was_xio(end_was_xio), .end_was_bsi(end_was_bsi),
    .branch_done(branch_done), .branch_bo(branch_bo),
    .take_irq(take2), .vector(vector2), .grant_level(grant2),
    .active(active2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_set(input logic [26:0] m);
    for (int i = 0; i < 27; i++) if (m[i]) return i;
    return 27;
  endfunction

  function automatic int vec_exp(input int p);
    if (p == 0)  return 8;
    if (p == 25) return 9;
    if (p == 26) return 10;
    return p + 10;
  endfunction

  task automatic idle_inputs();
    int_req = 0; trace_req = 0; ce_req = 0; ext_req = '0;
    insn_end = 0; end_was_xio = 0; end_was_bsi = 0;
    branch_done = 0; branch_bo = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    m_act = '0;
  endtask

  // One clock with the current inputs, checked against the model.
  task automatic step(input string tag);
    logic [26:0] c, a1, nxt;
    int p, a;
    bit acc;
    c = '0;
    if (insn_end) begin
      c[0]  = int_req;
      c[25] = trace_req;
      c[26] = ce_req;
      if (!(end_was_xio || end_was_bsi)) c[24:1] = ext_req;
    end
    a1 = m_act;
    if (branch_done && branch_bo && m_act != '0) a1[first_set(m_act)] = 1'b0;
    p = first_set(c);
    a = first_set(a1);
    acc = (p < 27) && (p < a);
    nxt = a1;
    if (acc) nxt[p] = 1'b1;
    @(posedge clk);
    #1;
    chk({tag, " take"}, 32'(take_irq), 32'(acc));
    if (acc) begin
      chk({tag, " grant"}, 32'(grant_level), 32'(p));
      chk({tag, " vector"}, 32'(vector), 32'(vec_exp(p)));
    end
    chk({tag, " active"}, 32'(active), 32'(nxt));
    m_act = nxt;
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    do_reset();
    // R1
    chk("R1 active", 32'(active), 0);
    chk("R1 take", 32'(take_irq), 0);

    // R2: request without a boundary strobe
    ext_req[3] = 1; step("R2");
    chk("R2 no take", 32'(take_irq), 0);

    // R3/R6: all of int, ext5, trace, CE at once -> internal wins
    int_req = 1; ext_req[5] = 1; trace_req = 1; ce_req = 1; insn_end = 1; step("R3");
    chk("R3 grant internal", 32'(grant_level), 0);
    chk("R6 vector internal", 32'(vector), 8);
    // R4: equal level and lower levels held off
    int_req = 1; ext_req[5] = 1; ce_req = 1; insn_end = 1; step("R4");
    chk("R4 held off", 32'(take_irq), 0);
    branch_done = 1; branch_bo = 1; step("R7");
    chk("R7 cleared", 32'(active), 0);

    // Nesting
    ext_req[5] = 1; insn_end = 1; step("R5");
    chk("R5 grant ext5", 32'(grant_level), 6);
    chk("R6 vector ext5", 32'(vector), 16);
    step("R5");
    chk("R5 pulse one cycle", 32'(take_irq), 0);
    ext_req[2] = 1; insn_end = 1; step("R4");
    chk("R4 preempt ext2", 32'(grant_level), 3);
    ext_req[9] = 1; insn_end = 1; step("R4");
    chk("R4 lower held", 32'(take_irq), 0);
    branch_done = 1; branch_bo = 1; step("R7");
    chk("R7 only top cleared", 32'(active), 32'h40);
    branch_done = 1; branch_bo = 0; step("R8");
    chk("R8 plain branch", 32'(active), 32'h40);
    branch_done = 1; branch_bo = 1; step("R7");
    branch_done = 1; branch_bo = 1; step("R9");
    chk("R9 idle return", 32'(active), 0);

    // R10
    ext_req[0] = 1; trace_req = 1; insn_end = 1; end_was_xio = 1; step("R10");
    chk("R10 trace taken", 32'(grant_level), 25);
    chk("R6 vector trace", 32'(vector), 9);
    branch_done = 1; branch_bo = 1; step("R7");
    ext_req[0] = 1; insn_end = 1; end_was_bsi = 1; step("R10");
    chk("R10 ext blocked", 32'(take_irq), 0);
    ce_req = 1; insn_end = 1; end_was_bsi = 1; step("R10");
    chk("R10 CE taken", 32'(grant_level), 26);
    chk("R6 vector CE", 32'(vector), 10);

    // R11: group 2 disabled in the second instance
    do_reset();
    ext_req[20] = 1; insn_end = 1; step("R11");
    chk("R11 main ext20 vector", 32'(vector), 32'h1F);
    chk("R11 g2off no take", 32'(take2), 0);
    chk("R11 g2off active", 32'(active2), 0);
    ext_req[14] = 1; insn_end = 1;
    @(posedge clk); #1; idle_inputs();
    chk("R11 g2off grp1 taken", 32'(grant2), 15);
    m_act = active;

    // R12: return and boundary in the same cycle
    do_reset();
    ext_req[5] = 1; insn_end = 1; step("R12");
    ext_req[5] = 1; insn_end = 1; branch_done = 1; branch_bo = 1; step("R12");
    chk("R12 same level retaken", 32'(take_irq), 1);
    chk("R12 active", 32'(active), 32'h40);
    ext_req[2] = 1; insn_end = 1; step("R12");
    ext_req[7] = 1; insn_end = 1; branch_done = 1; branch_bo = 1; step("R12");
    chk("R12 below remaining held", 32'(take_irq), 0);
    chk("R12 remaining", 32'(active), 32'h40);

    // Random phase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      insn_end    = ($urandom_range(0, 1) == 0);
      int_req     = ($urandom_range(0, 31) == 0);
      trace_req   = ($urandom_range(0, 15) == 0);
      ce_req      = ($urandom_range(0, 15) == 0);
      for (int b = 0; b < 24; b++) ext_req[b] = ($urandom_range(0, 15) == 0);
      end_was_xio = ($urandom_range(0, 7) == 0);
      end_was_bsi = ($urandom_range(0, 7) == 0);
      branch_done = ($urandom_range(0, 2) == 0);
      branch_bo   = ($urandom_range(0, 1) == 0);
      step("R3/R4/R5/R6/R7/R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule